// File: doc/BRIEF.md
# Prioritized Timing Reference Selector

This block holds a small working table of candidate timing references and decides which one disciplines the local clock. Every entry couples a time-of-day source with a separate once-per-second pulse source, carries an enable bit and a priority number, and is chosen only when both of its sources are reported valid at once. Per-source validity flags arrive as inputs. The block outputs the chosen entry index, that entry's two source codes, and a holdover flag that is raised when no entry qualifies.

Software changes the working table through a one-cycle command port. It can write an entry, remove it, enable it, disable it or change its priority. It can also overwrite the whole table from a built-in factory table or from a saved user table, and copy the working table into the user table. The user table is a register bank that is not cleared by reset. Once it has been saved, every reset starts the working table from that bank instead of the factory table.

A serial scanner examines one entry per cycle and publishes its result once per full pass. Any change to the working table restarts the pass, so the outputs keep their last value until a complete scan of the new table has finished.

Top module: `ref_selector`

## Requirements
- R1: A table entry reads back on `rd_entry_o` as {used[10], enable[9], priority[8:6], time source[5:3], pulse source[2:0]}. Source codes are GPS=0, DCLS=1, AM=2, EXTPPS=3, HOST=4, SELF=5.
- R2: The selected entry is the used, enabled entry with the smallest priority number whose time source and pulse source are both valid. When priorities are equal, the lower index wins.
- R3: An entry qualifies only when both halves are valid. Mixed pairs are allowed, and a valid time source paired with an invalid pulse source does not qualify.
- R4: SELF (code 5) is always treated as valid for both time and pulse, whatever the validity inputs say.
- R5: After reset with no saved user table, the working table holds the factory table. Entries 0..4 are used and enabled with priorities 1..5, as GPS/GPS, DCLS/DCLS, AM/AM, HOST/EXTPPS and HOST/SELF. Entry 5 is SELF/SELF with priority 6, used but disabled. Entries 6..7 are empty.
- R6: The command ops are ADD=0 (write a used entry with the given enable, priority and sources), DEL=1 (clear the entry to all zero), ENA=2, DIS=3 and PRIO=4 (write the priority). The change is visible on the readback one cycle after the command.
- R7: A command that changes the working table restarts the scan. The outputs hold their prior values for 7 cycles after the command edge and show the new result on the 8th edge.
- R8: SAVE=7 copies the working table into the user table. LDDEF=5 reloads the working table from the factory table. LDUSR=6 reloads it from the user table, and LDUSR has no effect before any SAVE.
- R9: After a SAVE, a reset starts the working table from the user table.
- R10: When a scan finds no qualifying entry, `holdover_o` is 1 and the selected index and source codes keep their last values.
- R11: From reset until the first scan completes, `holdover_o` is 1 and the selected index and source codes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tvalid_i | input | 6 | Time-of-day validity per source code 0..5 |
| pvalid_i | input | 6 | Pulse validity per source code 0..5 |
| cmd_valid_i | input | 1 | Command strobe, one cycle |
| cmd_op_i | input | 3 | Command op code |
| cmd_idx_i | input | 3 | Target entry index |
| cmd_en_i | input | 1 | Enable bit for ADD |
| cmd_prio_i | input | 3 | Priority for ADD and PRIO |
| cmd_tsrc_i | input | 3 | Time source code for ADD |
| cmd_psrc_i | input | 3 | Pulse source code for ADD |
| rd_idx_i | input | 3 | Working table readback index |
| rd_entry_o | output | 11 | Working table entry at `rd_idx_i` |
| sel_idx_o | output | 3 | Selected entry index |
| sel_tsrc_o | output | 3 | Time source of the selected entry |
| sel_psrc_o | output | 3 | Pulse source of the selected entry |
| holdover_o | output | 1 | No entry qualified in the last scan |

## Verification
Selection is driven with several validity patterns.

- All sources valid shows that the priority order is respected.
- A pattern that drops only the GPS time half shows that a half-valid pair is skipped.
- A pattern with only host time and external pulse valid selects a mixed pair.
- Clearing all inputs separates the forced-valid SELF entry, once it is enabled, from holdover.

Priority edits that create a tie at equal priority show that the lower index wins. A cycle-by-cycle check around an enable command tells a scan that restarts apart from one that publishes mid-pass. Save, load and reset sequences, with a distinctive mixed entry in the table, show which bank reached the working table.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

    localparam int N_ENT     = 8;
    localparam int IDX_W     = $clog2(N_ENT);
    localparam int PRIO_W    = 3;
    localparam int SRC_W     = 3;
    localparam int N_SRC     = 6;
    localparam int SRC_SPACE = 1 << SRC_W;

    localparam logic [SRC_W-1:0] SRC_GPS    = 3'd0;
    localparam logic [SRC_W-1:0] SRC_DCLS   = 3'd1;
    localparam logic [SRC_W-1:0] SRC_AM     = 3'd2;
    localparam logic [SRC_W-1:0] SRC_EXTPPS = 3'd3;
    localparam logic [SRC_W-1:0] SRC_HOST   = 3'd4;
    localparam logic [SRC_W-1:0] SRC_SELF   = 3'd5;

    typedef enum logic [2:0] {
        OP_ADD   = 3'd0,
        OP_DEL   = 3'd1,
        OP_ENA   = 3'd2,
        OP_DIS   = 3'd3,
        OP_PRIO  = 3'd4,
        OP_LDDEF = 3'd5,
        OP_LDUSR = 3'd6,
        OP_SAVE  = 3'd7
    } op_e;

    typedef struct packed {
        logic              used;
        logic              en;
        logic [PRIO_W-1:0] prio;
        logic [SRC_W-1:0]  tsrc;
        logic [SRC_W-1:0]  psrc;
    } ent_t;

    localparam int ENT_W = $bits(ent_t);

    function automatic ent_t mk_ent(logic u, logic e, logic [PRIO_W-1:0] p,
                                    logic [SRC_W-1:0] t, logic [SRC_W-1:0] s);
        ent_t r;
        r.used = u;
        r.en   = e;
        r.prio = p;
        r.tsrc = t;
        r.psrc = s;
        return r;
    endfunction

    // Built-in factory table
    function automatic ent_t factory_ent(int unsigned i);
        case (i)
            0:       return mk_ent(1'b1, 1'b1, 3'd1, SRC_GPS,  SRC_GPS);
            1:       return mk_ent(1'b1, 1'b1, 3'd2, SRC_DCLS, SRC_DCLS);
            2:       return mk_ent(1'b1, 1'b1, 3'd3, SRC_AM,   SRC_AM);
            3:       return mk_ent(1'b1, 1'b1, 3'd4, SRC_HOST, SRC_EXTPPS);
            4:       return mk_ent(1'b1, 1'b1, 3'd5, SRC_HOST, SRC_SELF);
            5:       return mk_ent(1'b1, 1'b0, 3'd6, SRC_SELF, SRC_SELF);
            default: return '0;
        endcase
    endfunction

    // Widen per-source flags to the full code space; SELF is always valid
    function automatic logic [SRC_SPACE-1:0] widen_valid(logic [N_SRC-1:0] v);
        logic [SRC_SPACE-1:0] w;
        w = '0;
        w[N_SRC-1:0] = v;
        w[SRC_SELF]  = 1'b1;
        return w;
    endfunction

endpackage

// File: rtl/refsel_table.sv
module refsel_table
    import refsel_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid_i,
    input  op_e              cmd_op_i,
    input  logic [IDX_W-1:0] cmd_idx_i,
    input  ent_t             cmd_ent_i,
    output ent_t             work_o [N_ENT],
    output logic             edit_o
);

    // Retained bank: only SAVE writes it, reset leaves it alone
    logic user_ok_q = 1'b0;

    always_ff @(posedge clk) begin
        if (cmd_valid_i && cmd_op_i == OP_SAVE) user_ok_q <= 1'b1;
    end

    always_comb begin
        edit_o = 1'b0;
        if (cmd_valid_i) begin
            case (cmd_op_i)
                OP_ADD, OP_DEL, OP_ENA, OP_DIS, OP_PRIO, OP_LDDEF: edit_o = 1'b1;
                OP_LDUSR: edit_o = user_ok_q;
                default:  edit_o = 1'b0;
            endcase
        end
    end

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        ent_t work_q;
        ent_t user_q;
        logic hit;

        assign hit       = (cmd_idx_i == IDX_W'(g));
        assign work_o[g] = work_q;

        always_ff @(posedge clk) begin
            if (cmd_valid_i && cmd_op_i == OP_SAVE) user_q <= work_q;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                work_q <= user_ok_q ? user_q : factory_ent(g);
            end else if (cmd_valid_i) begin
                case (cmd_op_i)
                    OP_ADD: if (hit) begin
                        work_q.used <= 1'b1;
                        work_q.en   <= cmd_ent_i.en;
                        work_q.prio <= cmd_ent_i.prio;
                        work_q.tsrc <= cmd_ent_i.tsrc;
                        work_q.psrc <= cmd_ent_i.psrc;
                    end
                    OP_DEL:   if (hit) work_q <= '0;
                    OP_ENA:   if (hit) work_q.en <= 1'b1;
                    OP_DIS:   if (hit) work_q.en <= 1'b0;
                    OP_PRIO:  if (hit) work_q.prio <= cmd_ent_i.prio;
                    OP_LDDEF: work_q <= factory_ent(g);
                    OP_LDUSR: if (user_ok_q) work_q <= user_q;
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/refsel_scan.sv
module refsel_scan
    import refsel_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 restart_i,
    input  ent_t                 tbl_i [N_ENT],
    input  logic [SRC_SPACE-1:0] tv_i,
    input  logic [SRC_SPACE-1:0] pv_i,
    output logic [IDX_W-1:0]     sel_idx_o,
    output logic [SRC_W-1:0]     sel_tsrc_o,
    output logic [SRC_W-1:0]     sel_psrc_o,
    output logic                 holdover_o,
    output logic                 done_o,
    output logic                 found_o,
    output logic [IDX_W-1:0]     cnt_o
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENT - 1);

    logic [IDX_W-1:0]  cnt_q;
    logic              found_q;
    logic [IDX_W-1:0]  best_idx_q;
    logic [PRIO_W-1:0] best_prio_q;
    logic [SRC_W-1:0]  best_t_q, best_p_q;

    ent_t              cur;
    logic              qual, better;
    logic              nx_found;
    logic [IDX_W-1:0]  nx_idx;
    logic [PRIO_W-1:0] nx_prio;
    logic [SRC_W-1:0]  nx_t, nx_p;

    always_comb begin
        cur      = tbl_i[cnt_q];
        qual     = cur.used && cur.en && tv_i[cur.tsrc] && pv_i[cur.psrc];
        better   = qual && (!found_q || (cur.prio < best_prio_q));
        nx_found = found_q | qual;
        nx_idx   = better ? cnt_q    : best_idx_q;
        nx_prio  = better ? cur.prio : best_prio_q;
        nx_t     = better ? cur.tsrc : best_t_q;
        nx_p     = better ? cur.psrc : best_p_q;
    end

    assign done_o  = (cnt_q == LAST) && !restart_i;
    assign found_o = nx_found;
    assign cnt_o   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q       <= '0;
            found_q     <= 1'b0;
            best_idx_q  <= '0;
            best_prio_q <= '0;
            best_t_q    <= '0;
            best_p_q    <= '0;
            sel_idx_o   <= '0;
            sel_tsrc_o  <= '0;
            sel_psrc_o  <= '0;
            holdover_o  <= 1'b1;
        end else if (restart_i) begin
            cnt_q   <= '0;
            found_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q   <= '0;
            found_q <= 1'b0;
            if (nx_found) begin
                sel_idx_o  <= nx_idx;
                sel_tsrc_o <= nx_t;
                sel_psrc_o <= nx_p;
                holdover_o <= 1'b0;
            end else begin
                holdover_o <= 1'b1;
            end
        end else begin
            cnt_q       <= cnt_q + 1'b1;
            found_q     <= nx_found;
            best_idx_q  <= nx_idx;
            best_prio_q <= nx_prio;
            best_t_q    <= nx_t;
            best_p_q    <= nx_p;
        end
    end

endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import refsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [N_SRC-1:0]   tvalid_i,
    input  logic [N_SRC-1:0]   pvalid_i,
    input  logic               cmd_valid_i,
    input  logic [2:0]         cmd_op_i,
    input  logic [IDX_W-1:0]   cmd_idx_i,
    input  logic               cmd_en_i,
    input  logic [PRIO_W-1:0]  cmd_prio_i,
    input  logic [SRC_W-1:0]   cmd_tsrc_i,
    input  logic [SRC_W-1:0]   cmd_psrc_i,
    input  logic [IDX_W-1:0]   rd_idx_i,
    output logic [ENT_W-1:0]   rd_entry_o,
    output logic [IDX_W-1:0]   sel_idx_o,
    output logic [SRC_W-1:0]   sel_tsrc_o,
    output logic [SRC_W-1:0]   sel_psrc_o,
    output logic               holdover_o
);

    ent_t                 work_tbl [N_ENT];
    ent_t                 cmd_ent;
    logic                 tbl_edit;
    logic                 scan_done, scan_found;
    logic [IDX_W-1:0]     scan_cnt;
    logic [SRC_SPACE-1:0] tv_eff, pv_eff;

    assign cmd_ent = mk_ent(1'b1, cmd_en_i, cmd_prio_i, cmd_tsrc_i, cmd_psrc_i);
    assign tv_eff  = widen_valid(tvalid_i);
    assign pv_eff  = widen_valid(pvalid_i);

    refsel_table i_table (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid_i (cmd_valid_i),
        .cmd_op_i    (op_e'(cmd_op_i)),
        .cmd_idx_i   (cmd_idx_i),
        .cmd_ent_i   (cmd_ent),
        .work_o      (work_tbl),
        .edit_o      (tbl_edit)
    );

    refsel_scan i_scan (
        .clk        (clk),
        .rst        (rst),
        .restart_i  (tbl_edit),
        .tbl_i      (work_tbl),
        .tv_i       (tv_eff),
        .pv_i       (pv_eff),
        .sel_idx_o  (sel_idx_o),
        .sel_tsrc_o (sel_tsrc_o),
        .sel_psrc_o (sel_psrc_o),
        .holdover_o (holdover_o),
        .done_o     (scan_done),
        .found_o    (scan_found),
        .cnt_o      (scan_cnt)
    );

    assign rd_entry_o = work_tbl[rd_idx_i];

endmodule

// File: rtl/refsel_chk.sv
module refsel_chk
    import refsel_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             done,
    input logic             found,
    input logic             restart,
    input logic [IDX_W-1:0] cnt,
    input ent_t             tbl [N_ENT],
    input logic [IDX_W-1:0] sel_idx,
    input logic [SRC_W-1:0] sel_tsrc,
    input logic [SRC_W-1:0] sel_psrc,
    input logic             holdover
);

    // R7
    out_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !done |=> $stable({sel_idx, sel_tsrc, sel_psrc, holdover}));

    // R7
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

    // R10
    holdover_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !found) |=> (holdover && $stable(sel_idx) && $stable(sel_tsrc)));

    // R2
    sel_match_chk: assert property (@(posedge clk) disable iff (rst)
        (done && found) |=> (!holdover && tbl[sel_idx].used && tbl[sel_idx].en
                             && tbl[sel_idx].tsrc == sel_tsrc
                             && tbl[sel_idx].psrc == sel_psrc));

endmodule

bind ref_selector refsel_chk i_refsel_chk (
    .clk      (clk),
    .rst      (rst),
    .done     (scan_done),
    .found    (scan_found),
    .restart  (tbl_edit),
    .cnt      (scan_cnt),
    .tbl      (work_tbl),
    .sel_idx  (sel_idx_o),
    .sel_tsrc (sel_tsrc_o),
    .sel_psrc (sel_psrc_o),
    .holdover (holdover_o)
);

// File: tb/test_ref_selector.sv
module test_ref_selector;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  tvalid = '0, pvalid = '0;
    logic        cmd_valid = 1'b0;
    logic [2:0]  cmd_op = '0, cmd_idx = '0, cmd_prio = '0, cmd_tsrc = '0, cmd_psrc = '0;
    logic        cmd_en = 1'b0;
    logic [2:0]  rd_idx = '0;
    logic [10:0] rd_entry;
    logic [2:0]  sel_idx, sel_tsrc, sel_psrc;
    logic        holdover;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    ref_selector i_ref_selector (
        .clk(clk), .rst(rst), .tvalid_i(tvalid), .pvalid_i(pvalid),
        .cmd_valid_i(cmd_valid), .cmd_op_i(cmd_op), .cmd_idx_i(cmd_idx),
        .cmd_en_i(cmd_en), .cmd_prio_i(cmd_prio), .cmd_tsrc_i(cmd_tsrc),
        .cmd_psrc_i(cmd_psrc), .rd_idx_i(rd_idx), .rd_entry_o(rd_entry),
        .sel_idx_o(sel_idx), .sel_tsrc_o(sel_tsrc), .sel_psrc_o(sel_psrc),
        .holdover_o(holdover)
    );

    function automatic logic [10:0] ent(logic u, logic e, logic [2:0] p,
                                        logic [2:0] t, logic [2:0] s);
        return {u, e, p, t, s};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(logic [2:0] op, logic [2:0] idx, logic en,
                       logic [2:0] p, logic [2:0] t, logic [2:0] s);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
        cmd_en = en; cmd_prio = p; cmd_tsrc = t; cmd_psrc = s;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic read_check(string req, logic [2:0] idx, logic [10:0] exp);
        rd_idx = idx;
        #1;
        check(req, rd_entry, exp);
    endtask

    task automatic sel_check(string req, logic [2:0] idx, logic [2:0] t,
                             logic [2:0] s, logic h);
        check(req, {holdover, sel_idx, sel_tsrc, sel_psrc}, {h, idx, t, s});
    endtask

    task automatic t_reset();
        tick(3);
        rst = 1'b0;
        sel_check("R11 reset outputs", 3'd0, 3'd0, 3'd0, 1'b1);
        read_check("R5 R1 entry0", 3'd0, ent(1, 1, 1, 0, 0));
        read_check("R5 entry1",    3'd1, ent(1, 1, 2, 1, 1));
        read_check("R5 entry2",    3'd2, ent(1, 1, 3, 2, 2));
        read_check("R5 entry3",    3'd3, ent(1, 1, 4, 4, 3));
        read_check("R5 entry4",    3'd4, ent(1, 1, 5, 4, 5));
        read_check("R5 entry5",    3'd5, ent(1, 0, 6, 5, 5));
        read_check("R5 entry6",    3'd6, '0);
        read_check("R5 entry7",    3'd7, '0);
    endtask

    task automatic t_all_valid();
        tvalid = 6'h3F; pvalid = 6'h3F;
        tick(16);
        sel_check("R2 all valid picks GPS", 3'd0, 3'd0, 3'd0, 1'b0);
        cmd(3'd6, 3'd0, 0, 0, 0, 0);
        tick(16);
        read_check("R8 LDUSR without save", 3'd0, ent(1, 1, 1, 0, 0));
        sel_check("R8 LDUSR without save keeps sel", 3'd0, 3'd0, 3'd0, 1'b0);
    endtask

    task automatic t_pairs();
        tvalid = 6'h3E; pvalid = 6'h3F;
        tick(16);
        sel_check("R3 GPS time missing", 3'd1, 3'd1, 3'd1, 1'b0);
        tvalid = 6'h10; pvalid = 6'h08;
        tick(16);
        sel_check("R3 host/ext pair", 3'd3, 3'd4, 3'd3, 1'b0);
        pvalid = 6'h00;
        tick(16);
        sel_check("R4 host/self pair", 3'd4, 3'd4, 3'd5, 1'b0);
    endtask

    task automatic t_holdover_enable();
        tvalid = 6'h00; pvalid = 6'h00;
        tick(16);
        sel_check("R10 holdover keeps last", 3'd4, 3'd4, 3'd5, 1'b1);
        cmd(3'd2, 3'd5, 0, 0, 0, 0);
        read_check("R6 ENA entry5", 3'd5, ent(1, 1, 6, 5, 5));
        tick(7);
        sel_check("R7 held before scan end", 3'd4, 3'd4, 3'd5, 1'b1);
        tick(1);
        sel_check("R7 R4 self selected on 8th edge", 3'd5, 3'd5, 3'd5, 1'b0);
    endtask

    task automatic t_prio();
        tvalid = 6'h3F; pvalid = 6'h3F;
        tick(16);
        sel_check("R2 back to GPS", 3'd0, 3'd0, 3'd0, 1'b0);
        cmd(3'd4, 3'd2, 0, 3'd0, 0, 0);
        read_check("R6 PRIO entry2", 3'd2, ent(1, 1, 0, 2, 2));
        tick(8);
        sel_check("R6 R2 prio raised", 3'd2, 3'd2, 3'd2, 1'b0);
        cmd(3'd4, 3'd1, 0, 3'd0, 0, 0);
        tick(8);
        sel_check("R2 tie lower index", 3'd1, 3'd1, 3'd1, 1'b0);
    endtask

    task automatic t_delete_disable();
        cmd(3'd1, 3'd1, 0, 0, 0, 0);
        read_check("R6 DEL entry1", 3'd1, '0);
        tick(8);
        sel_check("R6 after DEL", 3'd2, 3'd2, 3'd2, 1'b0);
        cmd(3'd3, 3'd2, 0, 0, 0, 0);
        read_check("R6 DIS entry2", 3'd2, ent(1, 0, 0, 2, 2));
        tick(8);
        sel_check("R6 after DIS", 3'd0, 3'd0, 3'd0, 1'b0);
    endtask

    task automatic t_add_tables();
        tvalid = 6'h04; pvalid = 6'h01;
        cmd(3'd0, 3'd7, 1, 3'd0, 3'd2, 3'd0);
        read_check("R6 ADD entry7", 3'd7, ent(1, 1, 0, 2, 0));
        tick(8);
        sel_check("R3 mixed AM/GPS pair", 3'd7, 3'd2, 3'd0, 1'b0);
        cmd(3'd7, 3'd0, 0, 0, 0, 0);
        cmd(3'd5, 3'd0, 0, 0, 0, 0);
        read_check("R8 LDDEF entry7", 3'd7, '0);
        read_check("R8 LDDEF entry1", 3'd1, ent(1, 1, 2, 1, 1));
        tick(8);
        sel_check("R10 no default qualifies", 3'd7, 3'd2, 3'd0, 1'b1);
        cmd(3'd6, 3'd0, 0, 0, 0, 0);
        read_check("R8 LDUSR entry7", 3'd7, ent(1, 1, 0, 2, 0));
        read_check("R8 LDUSR entry1", 3'd1, '0);
        tick(8);
        sel_check("R8 user table selection", 3'd7, 3'd2, 3'd0, 1'b0);
        cmd(3'd5, 3'd0, 0, 0, 0, 0);
        @(negedge clk);
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        read_check("R9 reset loads user entry7", 3'd7, ent(1, 1, 0, 2, 0));
        read_check("R9 reset loads user entry5", 3'd5, ent(1, 1, 6, 5, 5));
        tick(8);
        sel_check("R9 selection after reset", 3'd7, 3'd2, 3'd0, 1'b0);
    endtask

    initial begin
        t_reset();
        t_all_valid();
        t_pairs();
        t_holdover_enable();
        t_prio();
        t_delete_disable();
        t_add_tables();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog R7: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule